// File: doc/BRIEF.md
# Event Fragment Receive Checker

This block sits on a 128-bit word stream that carries event fragments and checks every fragment as it passes through. A fragment begins with a header word whose top byte is 0x55 and ends with a trailer word whose top byte is 0xAA. Words that arrive outside a fragment are thrown away and counted. Inside a fragment the block keeps a running USB CRC-16, counts words and compares the header's source identifier with a configured value. When the trailer arrives it replaces the trailer's 16-bit status field with its own error bitmap. Header and payload words pass through unchanged.

A configured word limit protects downstream buffers from runaway fragments. If a fragment reaches that limit before its trailer, the block sends a trailer it builds itself and flags the cut. It then drops the rest of the input up to the real trailer. Both sides use a valid/ready handshake. The output side has a last flag on each trailer and one register stage.

Field layout of the trailer: marker [127:120], word count [119:96], CRC [35:20], status [15:0]. The header carries its marker in [127:120] and the source identifier in its low `SRC_W` bits.

Top module: `frag_rx_checker`

## Requirements
- R1: While no fragment is open, a word whose top byte is not 0x55 is consumed and not forwarded. Each such word increments `drop_count`, which saturates at its all-ones value.
- R2: Header and payload words are forwarded unchanged and in order, one cycle after acceptance. Every forwarded trailer carries top byte 0xAA and `out_last`=1, and no other forwarded word has `out_last` set.
- R3: The CRC is the USB CRC-16: reflected polynomial 0xA001, seed 0xFFFF, data taken from bit 0 upward across each word and word after word from the header, result complemented. It covers every word of the fragment, with trailer bits [35:20] and [15:0] taken as zero. A mismatch with trailer field [35:20] sets status bit 0.
- R4: If trailer field [119:96] differs from the number of words in the fragment, counting both header and trailer, status bit 0 is set.
- R5: Status bit 2 is set when header bits [SRC_W-1:0] differ from `cfg_source`.
- R6: Status bit 3 is set if `sync_lost`, and status bit 1 is set if `link_err`, was high on any accepted word from the header to the trailer.
- R7: Status bits [15:5] of a forwarded trailer are zero, and the incoming status field has no effect on the output. All other trailer bits pass through unchanged.
- R8: A non-trailer word that would become word number `cfg_max_words` is replaced by a built trailer. That trailer holds 0xAA, count `cfg_max_words`, zero in [95:36] and [19:16], a valid CRC over the words forwarded plus itself, and status bit 4 set together with the bits of R5 and R6.
- R9: After a cut, input up to and including the next 0xAA word is consumed without output and without touching `drop_count`. The fragment that follows is handled normally.
- R10: While `out_valid` is high and `out_ready` is low, the output word and last flag are held. `in_ready` equals `!out_valid || out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 128 | Input word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 128 | Output word |
| out_last | output | 1 | Output word is a trailer |
| cfg_source | input | SRC_W | Expected source identifier |
| cfg_max_words | input | 24 | Word limit per fragment, header and trailer included |
| sync_lost | input | 1 | Synchronisation lost indication |
| link_err | input | 1 | Link-level CRC error indication |
| drop_count | output | CNT_W | Saturating count of words dropped outside fragments |

## Verification
The assertions assume that `cfg_max_words` is at least 2 and does not change while a fragment is open. They also assume that payload words never carry 0xAA in their top byte. The word-bound and cut-trailer properties rely on both. The bench changes the limit only between fragments, after the output has drained. It builds payload words with a fixed top byte of 0x3C and junk words with 0x11, so no word can be mistaken for a marker. Backpressure comes from a fixed cycle pattern on `out_ready`, so the hold property is exercised on every fragment sent in that test.

// File: rtl/frag_pkg.sv
// Shared constants and types for the fragment receive checker.
// Assumes 128-bit words with fixed field positions in header and trailer.
package frag_pkg;
    localparam int WORD_W = 128;
    localparam int LEN_W  = 24;
    localparam int STAT_W = 16;

    localparam logic [7:0] SOF_MARK = 8'h55;
    localparam logic [7:0] EOF_MARK = 8'hAA;

    localparam logic [15:0] CRC_POLY_R = 16'hA001;
    localparam logic [15:0] CRC_SEED   = 16'hFFFF;

    // status bit positions
    localparam int ST_FE   = 0;
    localparam int ST_LINK = 1;
    localparam int ST_SRC  = 2;
    localparam int ST_SYNC = 3;
    localparam int ST_CUT  = 4;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_BODY = 2'd1,
        TRK_DROP = 2'd2
    } trk_state_e;
endpackage

// File: rtl/frag_crc16.sv
// Advances a reflected CRC-16 (poly 0xA001) over one 128-bit word,
// bit 0 first. Purely combinational; no seeding or final inversion.
module frag_crc16
    import frag_pkg::*;
(
    input  logic [15:0]       crc_in,
    input  logic [WORD_W-1:0] word,
    output logic [15:0]       crc_out
);
    logic [15:0] acc_c;
    logic        fb;

    // Shift every data bit through the LFSR in order.
    always_comb begin
        acc_c = crc_in;
        fb    = 1'b0;
        for (int i = 0; i < WORD_W; i++) begin
            fb    = acc_c[0] ^ word[i];
            acc_c = {1'b0, acc_c[15:1]};
            if (fb) begin
                acc_c = acc_c ^ CRC_POLY_R;
            end
        end
        crc_out = acc_c;
    end
endmodule

// File: rtl/frag_tracker.sv
// Fragment state machine: finds headers, counts words, keeps sticky error
// flags and the running CRC, and decides what word (if any) to emit for
// each accepted input word. Assumes cfg_max_words >= 2 and stays stable
// while a fragment is open, and that payload words never start with 0xAA.
module frag_tracker
    import frag_pkg::*;
#(
    parameter int SRC_W = 32,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [WORD_W-1:0] in_data,
    input  logic [LEN_W-1:0]  cfg_max_words,
    input  logic [SRC_W-1:0]  cfg_source,
    input  logic              sync_lost,
    input  logic              link_err,
    input  logic [15:0]       crc_word,
    input  logic [15:0]       crc_synth,
    output logic [15:0]       crc_run,
    output logic              emit,
    output logic [WORD_W-1:0] emit_data,
    output logic              emit_last,
    output logic [CNT_W-1:0]  drop_count
);
    localparam logic [CNT_W-1:0] DROP_MAX = {CNT_W{1'b1}};

    trk_state_e       state_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] cnt_nx;
    logic             src_bad_q;
    logic             sync_q;
    logic             link_q;
    logic             sync_now;
    logic             link_now;
    logic             fe_err;
    logic             is_sof;
    logic             is_eof;
    logic             hit_max;
    logic [STAT_W-1:0] st_eof;
    logic [STAT_W-1:0] st_cut;
    logic [WORD_W-1:0] synth_word;

    // Decode markers and derive the per-word comparisons.
    always_comb begin
        is_sof   = in_data[127:120] == SOF_MARK;
        is_eof   = in_data[127:120] == EOF_MARK;
        cnt_nx   = cnt_q + 1'b1;
        hit_max  = cnt_nx == cfg_max_words;
        sync_now = sync_q | sync_lost;
        link_now = link_q | link_err;
        fe_err   = ((~crc_word) != in_data[35:20]) || (cnt_nx != in_data[119:96]);
    end

    // Assemble status bitmaps for a real trailer and for a cut trailer.
    always_comb begin
        st_eof          = '0;
        st_eof[ST_FE]   = fe_err;
        st_eof[ST_LINK] = link_now;
        st_eof[ST_SRC]  = src_bad_q;
        st_eof[ST_SYNC] = sync_now;
        st_cut          = '0;
        st_cut[ST_LINK] = link_now;
        st_cut[ST_SRC]  = src_bad_q;
        st_cut[ST_SYNC] = sync_now;
        st_cut[ST_CUT]  = 1'b1;
        synth_word      = {EOF_MARK, cfg_max_words, 60'b0, ~crc_synth, 4'b0, st_cut};
    end

    // Choose the word to forward for the current accepted input.
    always_comb begin
        emit      = 1'b0;
        emit_data = in_data;
        emit_last = 1'b0;
        case (state_q)
            TRK_IDLE: emit = acc && is_sof;
            TRK_BODY: begin
                emit = acc;
                if (is_eof) begin
                    emit_last        = 1'b1;
                    emit_data[15:0]  = st_eof;
                end else if (hit_max) begin
                    emit_last = 1'b1;
                    emit_data = synth_word;
                end
            end
            default: emit = 1'b0;
        endcase
    end

    // Advance state, word count, running CRC and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= TRK_IDLE;
            cnt_q     <= '0;
            crc_run   <= CRC_SEED;
            src_bad_q <= 1'b0;
            sync_q    <= 1'b0;
            link_q    <= 1'b0;
        end else if (acc) begin
            case (state_q)
                TRK_IDLE: begin
                    if (is_sof) begin
                        state_q   <= TRK_BODY;
                        cnt_q     <= {{(LEN_W-1){1'b0}}, 1'b1};
                        crc_run   <= crc_word;
                        src_bad_q <= in_data[SRC_W-1:0] != cfg_source;
                        sync_q    <= sync_lost;
                        link_q    <= link_err;
                    end
                end
                TRK_BODY: begin
                    if (is_eof) begin
                        state_q <= TRK_IDLE;
                        crc_run <= CRC_SEED;
                    end else if (hit_max) begin
                        state_q <= TRK_DROP;
                        crc_run <= CRC_SEED;
                    end else begin
                        cnt_q   <= cnt_nx;
                        crc_run <= crc_word;
                        sync_q  <= sync_now;
                        link_q  <= link_now;
                    end
                end
                default: begin
                    if (is_eof) begin
                        state_q <= TRK_IDLE;
                    end
                end
            endcase
        end
    end

    // Count words dropped outside a fragment, saturating at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_count <= '0;
        end else if (acc && state_q == TRK_IDLE && !is_sof && drop_count != DROP_MAX) begin
            drop_count <= drop_count + 1'b1;
        end
    end

    AST_DROP_HOLD_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        drop_count == DROP_MAX |=> drop_count == DROP_MAX); // R1
    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        drop_count != DROP_MAX |=> (drop_count == $past(drop_count) || drop_count == $past(drop_count) + 1'b1)); // R1
    AST_CNT_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == TRK_BODY |-> cnt_q < cfg_max_words); // R8
    AST_DROP_NO_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == TRK_DROP |-> !emit); // R9
endmodule

// File: rtl/frag_out_reg.sv
// Single output register stage with valid/ready flow control.
// Loads a new word (or a bubble) whenever the slot is empty or drained.
module frag_out_reg #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_word,
    input  logic         in_last,
    output logic         ready_up,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         out_last,
    input  logic         out_ready
);
    assign ready_up = !out_valid || out_ready;

    // Capture the offered word when the slot is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (ready_up) begin
            out_valid <= in_vld;
            out_data  <= in_word;
            out_last  <= in_last;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R10
endmodule

// File: rtl/frag_rx_checker.sv
// Top of the fragment receive checker: forwards 128-bit fragments, checks
// CRC, length and source, rewrites trailer status, truncates long fragments.
// Assumes payload words never carry 0xAA in their top byte.
module frag_rx_checker
    import frag_pkg::*;
#(
    parameter int SRC_W = 32,
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [127:0]       in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [127:0]       out_data,
    output logic               out_last,
    input  logic [SRC_W-1:0]   cfg_source,
    input  logic [23:0]        cfg_max_words,
    input  logic               sync_lost,
    input  logic               link_err,
    output logic [CNT_W-1:0]   drop_count
);
    logic              acc;
    logic [WORD_W-1:0] masked_word;
    logic [WORD_W-1:0] synth_zero;
    logic [15:0]       crc_run;
    logic [15:0]       crc_word;
    logic [15:0]       crc_synth;
    logic              emit;
    logic [WORD_W-1:0] emit_data;
    logic              emit_last;

    assign acc = in_valid && in_ready;

    // Zero CRC and status fields of a trailer before it enters the CRC.
    always_comb begin
        if (in_data[127:120] == EOF_MARK) begin
            masked_word = {in_data[127:36], 16'b0, in_data[19:16], 16'b0};
        end else begin
            masked_word = in_data;
        end
        synth_zero = {EOF_MARK, cfg_max_words, 96'b0};
    end

    frag_crc16 u_crc_in (
        .crc_in  (crc_run),
        .word    (masked_word),
        .crc_out (crc_word)
    );

    frag_crc16 u_crc_cut (
        .crc_in  (crc_run),
        .word    (synth_zero),
        .crc_out (crc_synth)
    );

    frag_tracker #(
        .SRC_W (SRC_W),
        .CNT_W (CNT_W)
    ) u_trk (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc           (acc),
        .in_data       (in_data),
        .cfg_max_words (cfg_max_words),
        .cfg_source    (cfg_source),
        .sync_lost     (sync_lost),
        .link_err      (link_err),
        .crc_word      (crc_word),
        .crc_synth     (crc_synth),
        .crc_run       (crc_run),
        .emit          (emit),
        .emit_data     (emit_data),
        .emit_last     (emit_last),
        .drop_count    (drop_count)
    );

    frag_out_reg #(
        .W (WORD_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (emit),
        .in_word   (emit_data),
        .in_last   (emit_last),
        .ready_up  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_ready (out_ready)
    );

    AST_LAST_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> out_data[127:120] == EOF_MARK); // R2
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> out_data[15:5] == 11'b0); // R7
    AST_CUT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last && out_data[4] |-> out_data[119:96] == cfg_max_words); // R8
    AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (!out_valid || out_ready)); // R10
endmodule

// File: tb/sim_frag_rx_checker.sv
`timescale 1ns/1ps
module sim_frag_rx_checker;
    localparam logic [31:0] SRC_OK = 32'hCAFE_0042;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_data;
    logic         out_last;
    logic [31:0]  cfg_source = SRC_OK;
    logic [23:0]  cfg_max_words = 24'd64;
    logic         sync_lost = 1'b0;
    logic         link_err = 1'b0;
    logic [7:0]   drop_count;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit bp_en = 1'b0;
    bit done = 1'b0;
    int seed = 1;

    logic [127:0] tx[$];
    logic [127:0] ex[$];
    logic [127:0] rx[$];
    logic         rx_last[$];

    always #2.5 clk = ~clk;

    frag_rx_checker u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_data       (in_data),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_data      (out_data),
        .out_last      (out_last),
        .cfg_source    (cfg_source),
        .cfg_max_words (cfg_max_words),
        .sync_lost     (sync_lost),
        .link_err      (link_err),
        .drop_count    (drop_count)
    );

    // out_ready changes just after each rising edge
    always @(posedge clk) begin
        #1;
        cyc++;
        out_ready = bp_en ? (cyc % 3 != 0) : 1'b1;
    end

    // record words that transfer at the coming rising edge
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            rx.push_back(out_data);
            rx_last.push_back(out_last);
        end
    end

    function automatic logic [15:0] crc_bytes(input logic [15:0] c_in, input logic [127:0] w);
        logic [15:0] c;
        c = c_in;
        for (int b = 0; b < 16; b++) begin
            c = c ^ {8'h00, w[8*b +: 8]};
            for (int k = 0; k < 8; k++) begin
                c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
            end
        end
        return c;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic push(input logic [127:0] w);
        in_data  = w;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
    endtask

    // Build a fragment in tx and its expected output in ex.
    task automatic build(input logic [31:0] src, input int npay, input logic crc_flip,
                         input int len_adj, input logic [15:0] st_in, input logic [15:0] st_exp);
        logic [127:0] w;
        logic [15:0]  c;
        logic [15:0]  fc;
        tx.delete();
        ex.delete();
        w = {8'h55, 24'h00A0B0, 64'h0123_4567_89AB_CDEF, src};
        c = crc_bytes(16'hFFFF, w);
        tx.push_back(w);
        for (int p = 0; p < npay; p++) begin
            seed = seed * 5 + 17;
            w = {8'h3C, 24'(p), 32'(seed), 32'(seed ^ 32'h5A5A_A5A5), 32'(seed + 3)};
            c = crc_bytes(c, w);
            tx.push_back(w);
        end
        w = {8'hAA, 24'(npay + 2 + len_adj), 60'h0F0_F0F0_F0F0_F0F0, 16'h0000, 4'h9, 16'h0000};
        c = crc_bytes(c, w);
        fc = (~c) ^ {15'b0, crc_flip};
        w = {w[127:36], fc, w[19:16], st_in};
        tx.push_back(w);
        foreach (tx[i]) ex.push_back(tx[i]);
        ex[ex.size() - 1] = {w[127:16], st_exp};
    endtask

    task automatic send_and_compare(input string tag);
        rx.delete();
        rx_last.delete();
        foreach (tx[i]) push(tx[i]);
        in_valid = 1'b0;
        repeat (30) @(negedge clk);
        chk({tag, " word count"}, 128'(rx.size()), 128'(ex.size()));
        for (int i = 0; i < ex.size() && i < rx.size(); i++) begin
            chk($sformatf("%s word %0d", tag, i), rx[i], ex[i]);
            chk($sformatf("%s R2 last %0d", tag, i), 128'(rx_last[i]), 128'(i == ex.size() - 1));
        end
    endtask

    task automatic t_reset;
        chk("R10 reset out_valid", 128'(out_valid), 128'(0));
        chk("R10 reset in_ready", 128'(in_ready), 128'(1));
        chk("R1 reset drop_count", 128'(drop_count), 128'(0));
    endtask

    task automatic t_good;
        build(SRC_OK, 3, 1'b0, 0, 16'h0000, 16'h0000);
        send_and_compare("R2 R3 good fragment");
        build(SRC_OK, 0, 1'b0, 0, 16'h0000, 16'h0000);
        send_and_compare("R2 R3 empty payload");
    endtask

    task automatic t_bad_crc;
        build(SRC_OK, 4, 1'b1, 0, 16'h0000, 16'h0001);
        send_and_compare("R3 crc mismatch");
    endtask

    task automatic t_bad_len;
        build(SRC_OK, 2, 1'b0, 1, 16'h0000, 16'h0001);
        send_and_compare("R4 length mismatch");
    endtask

    task automatic t_bad_src;
        build(32'h1234_5678, 2, 1'b0, 0, 16'h0000, 16'h0004);
        send_and_compare("R5 source mismatch");
    endtask

    task automatic t_sync_link;
        build(SRC_OK, 3, 1'b0, 0, 16'h0000, 16'h000A);
        sync_lost = 1'b1;
        link_err  = 1'b1;
        send_and_compare("R6 sync and link flags");
        sync_lost = 1'b0;
        link_err  = 1'b0;
    endtask

    task automatic t_status_in;
        build(SRC_OK, 2, 1'b0, 0, 16'hFFFF, 16'h0000);
        send_and_compare("R7 incoming status ignored");
    endtask

    task automatic t_preamble;
        for (int i = 0; i < 3; i++) push({8'h11, 120'(i)});
        in_valid = 1'b0;
        build(SRC_OK, 1, 1'b0, 0, 16'h0000, 16'h0000);
        send_and_compare("R1 after junk");
        chk("R1 drop_count 3", 128'(drop_count), 128'(3));
        for (int i = 0; i < 300; i++) push({8'h11, 120'(i)});
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 drop_count saturated", 128'(drop_count), 128'(255));
    endtask

    task automatic t_cut;
        logic [15:0]  c;
        logic [127:0] tz;
        logic [7:0]   dc_before;
        dc_before = drop_count;
        cfg_max_words = 24'd6;
        build(SRC_OK, 8, 1'b0, 0, 16'h0000, 16'h0000);
        ex.delete();
        c = 16'hFFFF;
        for (int i = 0; i < 5; i++) begin
            ex.push_back(tx[i]);
            c = crc_bytes(c, tx[i]);
        end
        tz = {8'hAA, 24'd6, 96'b0};
        c = crc_bytes(c, tz);
        ex.push_back({8'hAA, 24'd6, 60'b0, ~c, 4'b0, 16'h0010});
        send_and_compare("R8 cut trailer");
        chk("R9 drop_count untouched", 128'(drop_count), 128'(dc_before));
        cfg_max_words = 24'd64;
        build(SRC_OK, 2, 1'b0, 0, 16'h0000, 16'h0000);
        send_and_compare("R9 next fragment after cut");
    endtask

    task automatic t_backpressure;
        bp_en = 1'b1;
        build(SRC_OK, 6, 1'b0, 0, 16'h0000, 16'h0000);
        send_and_compare("R10 backpressure");
        bp_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(5ns * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good();
        t_bad_crc();
        t_bad_len();
        t_bad_src();
        t_sync_link();
        t_status_in();
        t_preamble();
        t_cut();
        t_backpressure();
        done = 1'b1;
        summary();
    end
endmodule